// File: doc/BRIEF.md
# Load-Use and Branch Stall Cycle Accounting Unit

This unit sits next to an in-order issue stage and works out what each retired instruction costs in cycles. For every instruction it is given the source register numbers, each with its own valid flag, the destination register of a load if the instruction is a load, whether the instruction is a branch and whether that branch was taken, a base cycle count, and two flags that mark the first and last members of a group of instructions issued together.

A source register that a recent load wrote is charged a load-use stall. A taken branch is charged a fixed redirect penalty. The unit keeps running totals of all cycles, load stall cycles, branch stall cycles, taken branches and untaken branches. A group issued together is charged the cost of its most expensive member, once, when its last member retires. The unit never stalls the pipeline. It only reports cost.

All counters are 32 bits wide and wrap modulo 2^32. All outputs are registered and show the effect of an instruction on the clock edge where `instr_valid` is sampled high.

Top module: `stall_accounting`

## Requirements
- R1: While `rst` is high, every counter output, `cur_cycles`, and both register masks are set to zero on the next rising edge.
- R2: A source operand adds 2 load stall cycles when its valid bit in `src_vld` is 1 and its 4-bit number in `src_reg` is set in the active hazard mask. Source s occupies `src_reg[4*s+3:4*s]`. Each source is checked on its own, so two hits add 4. A source whose valid bit is 0 adds nothing, whatever its number field holds.
- R3: A load (`ld_vld`=1) sets bit `ld_reg` in a pending mask. After every instruction, the active mask becomes a copy of the pending mask. The next instruction therefore sees the load, even if it is in the same group. The pending mask is cleared only when an instruction with `grp_first`=1 retires, and that clear happens before that instruction's own load bit is added.
- R4: A branch (`br_vld`=1) with `br_taken`=1 adds 2 branch stall cycles and increments `br_taken_count`. A branch with `br_taken`=0 increments `br_untaken_count` and adds no stall. A non-branch changes neither count.
- R5: The cost of an instruction is `base_cycles` plus its branch stall plus its load stall. `cur_cycles` shows the cost of the most recently retired instruction.
- R6: When an instruction with `grp_last`=1 retires, `total_cycles` grows by the larger of its own cost and the cost of the previous non-last member of the group. If it also has `grp_first`=1, it grows by its own cost. An instruction with `grp_last`=0 leaves `total_cycles` unchanged.
- R7: `ld_stall_total` and `br_stall_total` add each instruction's load stall and branch stall on every retirement, whether or not the instruction is the last of its group.
- R8: When `instr_valid` is 0, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction retires this cycle |
| grp_first | input | 1 | First member of an issue group |
| grp_last | input | 1 | Last member of an issue group |
| src_vld | input | NUM_SRC (2) | Per-source operand present flags |
| src_reg | input | NUM_SRC*REG_W (8) | Packed source register numbers |
| ld_vld | input | 1 | Instruction is a load |
| ld_reg | input | REG_W (4) | Load destination register |
| br_vld | input | 1 | Instruction is a branch |
| br_taken | input | 1 | Branch was taken |
| base_cycles | input | BASE_W (8) | Base cycle cost |
| cur_cycles | output | CNT_W (32) | Cost of the last retired instruction |
| total_cycles | output | CNT_W (32) | Accumulated group-charged cycles |
| ld_stall_total | output | CNT_W (32) | Accumulated load stall cycles |
| br_stall_total | output | CNT_W (32) | Accumulated branch stall cycles |
| br_taken_count | output | CNT_W (32) | Taken branch count |
| br_untaken_count | output | CNT_W (32) | Untaken branch count |

## Verification
The assertions check every cycle for properties that can be stated locally:
- the cleared state after reset,
- that every output holds when no instruction retires,
- that a non-last member leaves the total alone,
- the branch counter and stall steps,
- that an instruction with no valid sources adds no load stall,
- that the reported cost never falls below the base count.

Some behaviour depends on history, and only the bench's scenarios can show it. This includes which earlier load makes a source hazardous, the clearing of the pending mask at group starts, and charging the larger member of a pair. The bench checks these against its own model across directed sequences and randomized groups.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;

    localparam int unsigned STALL_W        = 8;
    localparam int unsigned LOAD_PENALTY   = 2;
    localparam int unsigned BRANCH_PENALTY = 2;

    typedef enum logic [1:0] {
        GRP_MID  = 2'b00,
        GRP_TAIL = 2'b01,
        GRP_HEAD = 2'b10,
        GRP_SOLO = 2'b11
    } grp_pos_e;

    typedef struct packed {
        logic [STALL_W-1:0] ld;
        logic [STALL_W-1:0] br;
    } stall_pair_t;

    function automatic grp_pos_e grp_pos(input logic first, input logic last);
        return grp_pos_e'({first, last});
    endfunction

    function automatic logic [31:0] max_u32(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sa_hazard_tracker.sv
module sa_hazard_tracker
    import stall_acct_pkg::*;
#(
    parameter int unsigned REG_W   = 4,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ev_valid,
    input  logic                     ev_first,
    input  logic [NUM_SRC-1:0]       src_vld,
    input  logic [NUM_SRC*REG_W-1:0] src_reg,
    input  logic                     ld_vld,
    input  logic [REG_W-1:0]         ld_reg,
    output logic [STALL_W-1:0]       ld_stall
);
    localparam int unsigned NREGS = 1 << REG_W;

    logic [NREGS-1:0]   pend_q;
    logic [NREGS-1:0]   act_q;
    logic [NREGS-1:0]   pend_nx;
    logic [NUM_SRC-1:0] hit;

    genvar s;
    generate
        for (s = 0; s < NUM_SRC; s++) begin : g_src
            logic [REG_W-1:0] rn;
            assign rn     = src_reg[s*REG_W +: REG_W];
            assign hit[s] = src_vld[s] & act_q[rn];
        end
    endgenerate

    always_comb begin
        ld_stall = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (hit[i]) ld_stall = ld_stall + STALL_W'(LOAD_PENALTY);
        end
    end

    always_comb begin
        pend_nx = ev_first ? '0 : pend_q;
        if (ld_vld) pend_nx[ld_reg] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else if (ev_valid) begin
            pend_q <= pend_nx;
            act_q  <= pend_nx;
        end
    end

endmodule

// File: rtl/sa_branch_tracker.sv
module sa_branch_tracker
    import stall_acct_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_valid,
    input  logic               br_vld,
    input  logic               br_taken,
    output logic [STALL_W-1:0] br_stall,
    output logic [CNT_W-1:0]   taken_cnt,
    output logic [CNT_W-1:0]   untaken_cnt
);
    assign br_stall = (br_vld && br_taken) ? STALL_W'(BRANCH_PENALTY) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_cnt   <= '0;
            untaken_cnt <= '0;
        end else if (ev_valid && br_vld) begin
            if (br_taken) taken_cnt   <= taken_cnt + 1'b1;
            else          untaken_cnt <= untaken_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sa_cycle_accum.sv
module sa_cycle_accum
    import stall_acct_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned BASE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic              ev_first,
    input  logic              ev_last,
    input  logic [BASE_W-1:0] base,
    input  stall_pair_t       stalls,
    output logic [CNT_W-1:0]  cur,
    output logic [CNT_W-1:0]  total,
    output logic [CNT_W-1:0]  ld_total,
    output logic [CNT_W-1:0]  br_total
);
    logic [CNT_W-1:0] cost;
    logic [CNT_W-1:0] grp_max_q;
    logic [CNT_W-1:0] charge;
    grp_pos_e         pos;

    assign cost = CNT_W'(base) + CNT_W'(stalls.br) + CNT_W'(stalls.ld);
    assign pos  = grp_pos(ev_first, ev_last);

    always_comb begin
        unique case (pos)
            GRP_SOLO: charge = cost;
            GRP_TAIL: charge = (cost > grp_max_q) ? cost : grp_max_q;
            default:  charge = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            total     <= '0;
            ld_total  <= '0;
            br_total  <= '0;
            grp_max_q <= '0;
        end else if (ev_valid) begin
            cur      <= cost;
            ld_total <= ld_total + CNT_W'(stalls.ld);
            br_total <= br_total + CNT_W'(stalls.br);
            if (ev_last) total     <= total + charge;
            else         grp_max_q <= cost;
        end
    end

endmodule

// File: rtl/stall_accounting.sv
module stall_accounting
    import stall_acct_pkg::*;
#(
    parameter int unsigned REG_W   = 4,
    parameter int unsigned NUM_SRC = 2,
    parameter int unsigned BASE_W  = 8,
    parameter int unsigned CNT_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     instr_valid,
    input  logic                     grp_first,
    input  logic                     grp_last,
    input  logic [NUM_SRC-1:0]       src_vld,
    input  logic [NUM_SRC*REG_W-1:0] src_reg,
    input  logic                     ld_vld,
    input  logic [REG_W-1:0]         ld_reg,
    input  logic                     br_vld,
    input  logic                     br_taken,
    input  logic [BASE_W-1:0]        base_cycles,
    output logic [CNT_W-1:0]         cur_cycles,
    output logic [CNT_W-1:0]         total_cycles,
    output logic [CNT_W-1:0]         ld_stall_total,
    output logic [CNT_W-1:0]         br_stall_total,
    output logic [CNT_W-1:0]         br_taken_count,
    output logic [CNT_W-1:0]         br_untaken_count
);
    stall_pair_t stalls;

    sa_hazard_tracker #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_haz (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (instr_valid),
        .ev_first (grp_first),
        .src_vld  (src_vld),
        .src_reg  (src_reg),
        .ld_vld   (ld_vld),
        .ld_reg   (ld_reg),
        .ld_stall (stalls.ld)
    );

    sa_branch_tracker #(.CNT_W(CNT_W)) u_br (
        .clk         (clk),
        .rst         (rst),
        .ev_valid    (instr_valid),
        .br_vld      (br_vld),
        .br_taken    (br_taken),
        .br_stall    (stalls.br),
        .taken_cnt   (br_taken_count),
        .untaken_cnt (br_untaken_count)
    );

    sa_cycle_accum #(.CNT_W(CNT_W), .BASE_W(BASE_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (instr_valid),
        .ev_first (grp_first),
        .ev_last  (grp_last),
        .base     (base_cycles),
        .stalls   (stalls),
        .cur      (cur_cycles),
        .total    (total_cycles),
        .ld_total (ld_stall_total),
        .br_total (br_stall_total)
    );

endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
    parameter int unsigned REG_W   = 4,
    parameter int unsigned NUM_SRC = 2,
    parameter int unsigned BASE_W  = 8,
    parameter int unsigned CNT_W   = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     instr_valid,
    input logic                     grp_first,
    input logic                     grp_last,
    input logic [NUM_SRC-1:0]       src_vld,
    input logic [NUM_SRC*REG_W-1:0] src_reg,
    input logic                     ld_vld,
    input logic [REG_W-1:0]         ld_reg,
    input logic                     br_vld,
    input logic                     br_taken,
    input logic [BASE_W-1:0]        base_cycles,
    input logic [CNT_W-1:0]         cur_cycles,
    input logic [CNT_W-1:0]         total_cycles,
    input logic [CNT_W-1:0]         ld_stall_total,
    input logic [CNT_W-1:0]         br_stall_total,
    input logic [CNT_W-1:0]         br_taken_count,
    input logic [CNT_W-1:0]         br_untaken_count
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cur_cycles == '0 && total_cycles == '0 && ld_stall_total == '0 &&
                 br_stall_total == '0 && br_taken_count == '0 && br_untaken_count == '0));

    assert_no_src_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && src_vld == '0) |=> $stable(ld_stall_total));

    assert_taken_step_R4: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && br_vld && br_taken) |=>
            (br_taken_count == $past(br_taken_count) + 1'b1 &&
             br_stall_total == $past(br_stall_total) + CNT_W'(2) &&
             $stable(br_untaken_count)));

    assert_untaken_step_R4: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && br_vld && !br_taken) |=>
            (br_untaken_count == $past(br_untaken_count) + 1'b1 &&
             $stable(br_taken_count) && $stable(br_stall_total)));

    assert_cost_floor_R5: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> (cur_cycles >= CNT_W'($past(base_cycles))));

    assert_nonlast_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !grp_last) |=> $stable(total_cycles));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> ($stable(cur_cycles) && $stable(total_cycles) &&
                          $stable(ld_stall_total) && $stable(br_stall_total) &&
                          $stable(br_taken_count) && $stable(br_untaken_count)));

endmodule

bind stall_accounting sa_checker #(
    .REG_W(REG_W), .NUM_SRC(NUM_SRC), .BASE_W(BASE_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_stall_accounting.sv
`timescale 1ns/1ps
module tb_stall_accounting;
    localparam int REG_W = 4, NUM_SRC = 2, BASE_W = 8, CNT_W = 32;

    logic clk = 1'b0;
    logic rst;
    logic instr_valid, grp_first, grp_last, ld_vld, br_vld, br_taken;
    logic [NUM_SRC-1:0]       src_vld;
    logic [NUM_SRC*REG_W-1:0] src_reg;
    logic [REG_W-1:0]         ld_reg;
    logic [BASE_W-1:0]        base_cycles;
    logic [CNT_W-1:0] cur_cycles, total_cycles, ld_stall_total, br_stall_total;
    logic [CNT_W-1:0] br_taken_count, br_untaken_count;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] m_pend, m_act;
    logic [31:0] m_gmax, m_cur, m_total, m_ldt, m_brt, m_tk, m_ut;

    always #10 clk = ~clk;

    stall_accounting dut (.*);

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_ld_stall(input logic [15:0] act,
            input logic [1:0] sv, input logic [7:0] sr);
        logic [31:0] r = 0;
        if (sv[0] && act[sr[3:0]]) r += 2;
        if (sv[1] && act[sr[7:4]]) r += 2;
        return r;
    endfunction

    function automatic logic [31:0] model_br_stall(input logic bv, input logic bt);
        return (bv && bt) ? 32'd2 : 32'd0;
    endfunction

    task automatic check_all();
        check("R5 cur_cycles", cur_cycles, m_cur);
        check("R6 total_cycles", total_cycles, m_total);
        check("R2/R7 ld_stall_total", ld_stall_total, m_ldt);
        check("R4/R7 br_stall_total", br_stall_total, m_brt);
        check("R4 br_taken_count", br_taken_count, m_tk);
        check("R4 br_untaken_count", br_untaken_count, m_ut);
    endtask

    task automatic issue(input logic f, input logic l, input logic [1:0] sv,
            input logic [7:0] sr, input logic lv, input logic [3:0] lr,
            input logic bv, input logic bt, input logic [7:0] base);
        logic [31:0] ld, br, cost;
        instr_valid = 1'b1; grp_first = f; grp_last = l;
        src_vld = sv; src_reg = sr; ld_vld = lv; ld_reg = lr;
        br_vld = bv; br_taken = bt; base_cycles = base;
        ld   = model_ld_stall(m_act, sv, sr);
        br   = model_br_stall(bv, bt);
        cost = 32'(base) + br + ld;
        if (f) m_pend = '0;
        if (lv) m_pend[lr] = 1'b1;
        m_act = m_pend;
        m_cur = cost; m_ldt += ld; m_brt += br;
        if (bv) begin
            if (bt) m_tk++; else m_ut++;
        end
        if (l) m_total += (f ? cost : ((cost > m_gmax) ? cost : m_gmax));
        else   m_gmax = cost;
        @(negedge clk);
        check_all();
    endtask

    task automatic idle(input int n);
        instr_valid = 1'b0;
        grp_first = $urandom; grp_last = $urandom; src_vld = 2'b11;
        br_vld = 1'b1; br_taken = 1'b1; ld_vld = 1'b1; base_cycles = 8'hff;
        repeat (n) @(negedge clk);
        check_all();
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; instr_valid = 1'b0; grp_first = 0; grp_last = 0;
        src_vld = 0; src_reg = 0; ld_vld = 0; ld_reg = 0; br_vld = 0; br_taken = 0;
        base_cycles = 0;
        m_pend = 0; m_act = 0; m_gmax = 0; m_cur = 0; m_total = 0;
        m_ldt = 0; m_brt = 0; m_tk = 0; m_ut = 0;
        repeat (3) @(negedge clk);
        check_all();
        check("R1 reset total", total_cycles, 32'd0);
        rst = 1'b0;

        // R3: a load is visible to the very next instruction; two hits add 4 (R2)
        issue(1, 1, 2'b00, 8'h00, 1, 4'd3, 0, 0, 8'd1);
        issue(1, 1, 2'b11, 8'h33, 0, 4'd0, 0, 0, 8'd1);
        check("R3 load-use on both sources", cur_cycles, 32'd5);
        // R3: pending cleared at group start, so r3 no longer hazardous
        issue(1, 1, 2'b01, 8'h03, 0, 4'd0, 0, 0, 8'd1);
        check("R3 cleared mask", cur_cycles, 32'd1);
        // R2: invalid source naming a loaded register adds nothing
        issue(1, 1, 2'b00, 8'h00, 1, 4'd7, 0, 0, 8'd1);
        issue(1, 1, 2'b10, 8'h27, 0, 4'd0, 0, 0, 8'd1);
        check("R2 invalid source ignored", cur_cycles, 32'd1);
        // R4: taken and untaken branches
        issue(1, 1, 2'b00, 8'h00, 0, 4'd0, 1, 1, 8'd1);
        check("R4 taken cost", cur_cycles, 32'd3);
        issue(1, 1, 2'b00, 8'h00, 0, 4'd0, 1, 0, 8'd1);
        check("R4 untaken cost", cur_cycles, 32'd1);
        // R6/R7: pair charged the larger member; load within group seen by tail
        begin
            logic [31:0] t0, l0;
            t0 = total_cycles;
            issue(1, 0, 2'b00, 8'h00, 1, 4'd9, 1, 1, 8'd5);
            check("R6 head leaves total", total_cycles, t0);
            check("R7 stall counted on head", br_stall_total, m_brt);
            l0 = ld_stall_total;
            issue(0, 1, 2'b01, 8'h09, 0, 4'd0, 0, 0, 8'd3);
            check("R3 same-group load visible", ld_stall_total, l0 + 32'd2);
            check("R6 pair charged max", total_cycles, t0 + 32'd7);
        end
        // R8: idle cycles with noisy inputs change nothing
        idle(5);
        check("R8 idle total", total_cycles, m_total);

        // randomized groups
        for (int i = 0; i < 400; i++) begin
            logic pair;
            pair = $urandom_range(0, 1);
            issue(1, !pair, 2'($urandom), 8'($urandom), ($urandom_range(0, 9) < 3),
                  4'($urandom), ($urandom_range(0, 9) < 3), 1'($urandom), 8'($urandom_range(0, 7)));
            if (pair)
                issue(0, 1, 2'($urandom), 8'($urandom), ($urandom_range(0, 9) < 3),
                      4'($urandom), ($urandom_range(0, 9) < 3), 1'($urandom), 8'($urandom_range(0, 7)));
            if ($urandom_range(0, 19) == 0) idle(2);
        end

        // R1: reset mid-run clears everything
        instr_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_pend = 0; m_act = 0; m_gmax = 0; m_cur = 0; m_total = 0;
        m_ldt = 0; m_brt = 0; m_tk = 0; m_ut = 0;
        check_all();
        issue(1, 1, 2'b11, 8'h77, 0, 4'd0, 0, 0, 8'd2);
        check("R1 masks cleared by reset", cur_cycles, 32'd2);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule